// File: doc/BRIEF.md
# Interrupt source state controller

This block holds the per-source state for a bank of interrupt sources and decides when each source hands a delivery request to the presentation layer that arbitrates between servers. Every source is fixed at build time as either level-sensitive or message-signalled. Each source has a target server, a current priority and a saved priority, and four flags: asserted, sent, rejected and masked-pending. The value 0xFF in the priority field masks a source. Sources are addressed from outside by a global number, which is the local index plus a base offset.

The block has five inputs. Source lines report events by local index. A configuration port takes read, write, disable and enable commands by global number and answers one cycle later. The presentation layer sends reject and end-of-interrupt notices by global number, and it sends resend requests. A resend starts a scan that visits one source per clock, from index 0 upward. A second resend during a scan restarts the scan at index 0.

Each source that decides to deliver raises its own pending slot. This slot keeps the server and priority in force at the moment of the decision. A fixed-priority picker presents the lowest-numbered pending slot on a valid/ready output.

When several inputs touch the same source in one cycle, they are applied in a fixed order:

1. The configuration write.
2. The source event.
3. The reject.
4. The end-of-interrupt.
5. The masked-pending release.
6. The level rule.
7. The scan step.

Top module: `irq_src_ctl`

## Requirements
- R1: After reset every flag is clear, every priority and saved priority is 0xFF and every server is 0. After reset no delivery request or configuration response is presented.
- R2: Configuration commands use global numbers from BASE to BASE+NUM_SRC-1, which map to local index number-BASE.
- R3: A number outside that range gets a response with the error bit set and changes no state. A write command also gets the error bit and changes nothing if its server index is NUM_SRV or more, or if its priority is above 0xFF.
- R4: A rising event on a message source whose priority is 0xFF sets masked-pending and delivers nothing. If the priority is anything else, the event is presented as a delivery in the next cycle, carrying the source's server and priority. A low event on a message source does nothing.
- R5: An event on a level source sets asserted when high and clears it when low.
- R6: A level source delivers only when its priority is not 0xFF, asserted is set and sent is clear. Delivering sets sent. The rule is evaluated on the source's events, on configuration writes and on scan visits.
- R7: A reject sets rejected and clears sent.
- R8: An end-of-interrupt clears sent on a level source and has no effect on a message source.
- R9: A resend scans every source in index order. A level source is then delivered by the rule in R6.
- R10: During a resend scan, a message source with rejected set clears the flag, and it delivers only if its priority is not 0xFF.
- R11: A write (cmd 1) stores server, priority and saved priority. A message source with masked-pending whose new priority is not 0xFF then clears the flag and delivers. A level source applies the rule in R6.
- R12: Disable (cmd 2) sets priority to 0xFF and copies the old priority into saved. Enable (cmd 3) copies saved into priority. A read (cmd 0) returns server and priority on the response port one cycle after the request. Responses to other commands return zeros.
- R13: The delivery output carries one request per cycle, lowest local index first. A request stays presented until it is taken with dlv_ready. A source that decides to deliver again while its request is still waiting is merged into that one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_valid | input | 1 | Source event strobe |
| ev_idx | input | IDX_W | Local index of the event source |
| ev_level | input | 1 | Event value (high or low) |
| cfg_valid | input | 1 | Configuration command strobe |
| cfg_cmd | input | 2 | 0 read, 1 write, 2 disable, 3 enable |
| cfg_num | input | NUM_W | Global source number |
| cfg_server | input | SRV_IN_W | Server index for a write |
| cfg_prio | input | PRIO_W+1 | Priority for a write (wide enough to detect values above 0xFF) |
| rsp_valid | output | 1 | Response strobe, one cycle after cfg_valid |
| rsp_err | output | 1 | Command refused |
| rsp_server | output | SRV_IN_W | Server returned by a read |
| rsp_prio | output | PRIO_W | Priority returned by a read |
| rej_valid | input | 1 | Reject notice strobe |
| rej_num | input | NUM_W | Global number being rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Global number being completed |
| resend_req | input | 1 | Start a resend scan |
| dlv_valid | output | 1 | Delivery request present |
| dlv_ready | input | 1 | Delivery request taken |
| dlv_server | output | SRV_IN_W | Target server of the delivery |
| dlv_num | output | NUM_W | Global number of the delivery |
| dlv_prio | output | PRIO_W | Priority of the delivery |

## Verification
Message sources are driven with events while masked and while unmasked. This shows the difference between a deferred delivery, released by a later write or enable, and an immediate one. Level sources are driven through assert, repeat assert, end-of-interrupt, reject and deassert. Each of these steps is followed by a resend, which shows how the sent and asserted flags gate redelivery. Rejects followed by disable, enable and end-of-interrupt separate the rejected flag's lifetime from the masking path. Several sources rejected together, and repeated events held behind a stalled output, show the ordering and merging of requests.

// File: rtl/irq_src_pkg.sv
// Shared encodings for the interrupt source state controller.
// Assumes: the command field is two bits wide and the flag vector is four bits wide.
package irq_src_pkg;

    typedef enum logic [1:0] {
        CMD_GET = 2'd0,
        CMD_SET = 2'd1,
        CMD_OFF = 2'd2,
        CMD_ON  = 2'd3
    } cfg_cmd_e;

    localparam int FLAG_W    = 4;
    localparam int FL_ASSERT = 0;
    localparam int FL_SENT   = 1;
    localparam int FL_REJECT = 2;
    localparam int FL_MPEND  = 3;

endpackage

// File: rtl/irq_num_dec.sv
// Converts a global source number into a local index and a one-hot hit vector.
// Assumes: BASE + N fits in NUM_W bits, and IDX_W <= NUM_W.
module irq_num_dec #(
    parameter int NUM_W = 12,
    parameter int N     = 8,
    parameter int IDX_W = 3,
    parameter int BASE  = 16
) (
    input  logic             valid,
    input  logic [NUM_W-1:0] num,
    output logic             in_rng,
    output logic [IDX_W-1:0] loc,
    output logic [N-1:0]     hit
);
    logic [NUM_W-1:0] off;

    // Range test and offset removal.
    always_comb begin
        off    = num - NUM_W'(BASE);
        in_rng = (num >= NUM_W'(BASE)) && (num < NUM_W'(BASE + N));
        loc    = off[IDX_W-1:0];
    end

    // One-hot select of the addressed source.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            hit[i] = valid && in_rng && (off == NUM_W'(i));
        end
    end
endmodule

// File: rtl/irq_resend_scan.sv
// Walks the source bank one index per clock after a resend request.
// Assumes: a request during a walk restarts the walk at index 0.
module irq_resend_scan #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         resend_req,
    output logic [N-1:0] scan_hit
);
    logic             active_q;
    logic [IDX_W-1:0] idx_q;

    // Scan position and activity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            idx_q    <= '0;
        end else if (resend_req) begin
            active_q <= 1'b1;
            idx_q    <= '0;
        end else if (active_q) begin
            if (idx_q == IDX_W'(N - 1)) begin
                active_q <= 1'b0;
            end
            idx_q <= idx_q + 1'b1;
        end
    end

    // Visit strobe for the current index.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            scan_hit[i] = active_q && (idx_q == IDX_W'(i));
        end
    end
endmodule

// File: rtl/irq_dlv_pick.sv
// Fixed-priority picker: grants the lowest-indexed pending delivery slot.
// Assumes: at most one grant per cycle is wanted.
module irq_dlv_pick #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic [N-1:0]     grant
);
    // Lowest set bit wins.
    always_comb begin
        any   = |req;
        idx   = '0;
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
        grant[idx] = any;
    end
endmodule

// File: rtl/irq_src_slot.sv
// State of one interrupt source: flags, priorities, server and a pending delivery slot.
// Assumes: the configuration fields already hold the values for the command.
// Same-cycle inputs apply in this order: config, event, reject, end-of-interrupt,
// masked-pending release, level rule, scan visit.
module irq_src_slot
    import irq_src_pkg::*;
#(
    parameter bit IS_LEVEL = 1'b0,
    parameter int SRV_W    = 2,
    parameter int PRIO_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_hit,
    input  logic              ev_val,
    input  logic              rej_hit,
    input  logic              eoi_hit,
    input  logic              cfg_hit,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic [PRIO_W-1:0] cfg_saved,
    input  logic [SRV_W-1:0]  cfg_srv,
    input  logic              scan_hit,
    input  logic              take,
    output logic [PRIO_W-1:0] prio_q,
    output logic [PRIO_W-1:0] saved_q,
    output logic [SRV_W-1:0]  srv_q,
    output logic              pend_q,
    output logic [PRIO_W-1:0] pend_prio_q,
    output logic [SRV_W-1:0]  pend_srv_q
);
    localparam logic [PRIO_W-1:0] MASKED = {PRIO_W{1'b1}};

    logic [FLAG_W-1:0] flags_q, flags_n;
    logic [PRIO_W-1:0] prio_n, saved_n;
    logic [SRV_W-1:0]  srv_n;
    logic              fire;

    // Next-state rules for one source.
    always_comb begin
        flags_n = flags_q;
        prio_n  = prio_q;
        saved_n = saved_q;
        srv_n   = srv_q;
        fire    = 1'b0;
        if (cfg_hit) begin
            prio_n  = cfg_prio;
            saved_n = cfg_saved;
            srv_n   = cfg_srv;
        end
        if (ev_hit) begin
            if (IS_LEVEL) begin
                flags_n[FL_ASSERT] = ev_val;
            end else if (ev_val) begin
                if (prio_n == MASKED) flags_n[FL_MPEND] = 1'b1;
                else                  fire = 1'b1;
            end
        end
        if (rej_hit) begin
            flags_n[FL_REJECT] = 1'b1;
            flags_n[FL_SENT]   = 1'b0;
        end
        if (eoi_hit && IS_LEVEL) begin
            flags_n[FL_SENT] = 1'b0;
        end
        if (!IS_LEVEL && cfg_hit && flags_n[FL_MPEND] && (prio_n != MASKED)) begin
            flags_n[FL_MPEND] = 1'b0;
            fire = 1'b1;
        end
        if (IS_LEVEL && (ev_hit || cfg_hit || scan_hit) && (prio_n != MASKED)
            && flags_n[FL_ASSERT] && !flags_n[FL_SENT]) begin
            flags_n[FL_SENT] = 1'b1;
            fire = 1'b1;
        end
        if (!IS_LEVEL && scan_hit && flags_n[FL_REJECT]) begin
            flags_n[FL_REJECT] = 1'b0;
            if (prio_n != MASKED) fire = 1'b1;
        end
    end

    // Source registers and the pending delivery slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q     <= '0;
            prio_q      <= MASKED;
            saved_q     <= MASKED;
            srv_q       <= '0;
            pend_q      <= 1'b0;
            pend_prio_q <= '0;
            pend_srv_q  <= '0;
        end else begin
            flags_q <= flags_n;
            prio_q  <= prio_n;
            saved_q <= saved_n;
            srv_q   <= srv_n;
            pend_q  <= (pend_q && !take) || fire;
            if (fire) begin
                pend_prio_q <= prio_n;
                pend_srv_q  <= srv_n;
            end
        end
    end
endmodule

// File: rtl/irq_src_ctl.sv
// Interrupt source state controller: a bank of level or message sources with
// configuration, reject, end-of-interrupt and resend handling, and one delivery output.
// Assumes: LEVEL_MAP marks level sources (bit set), SRV_IN_W >= SRV_W, NUM_W >= IDX_W.
module irq_src_ctl
    import irq_src_pkg::*;
#(
    parameter int NUM_SRC  = 8,
    parameter int SRC_BASE = 16,
    parameter int NUM_SRV  = 4,
    parameter int NUM_W    = 12,
    parameter int SRV_IN_W = 8,
    parameter int PRIO_W   = 8,
    parameter logic [NUM_SRC-1:0] LEVEL_MAP = 8'hF0,
    localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ev_valid,
    input  logic [IDX_W-1:0]    ev_idx,
    input  logic                ev_level,
    input  logic                cfg_valid,
    input  logic [1:0]          cfg_cmd,
    input  logic [NUM_W-1:0]    cfg_num,
    input  logic [SRV_IN_W-1:0] cfg_server,
    input  logic [PRIO_W:0]     cfg_prio,
    output logic                rsp_valid,
    output logic                rsp_err,
    output logic [SRV_IN_W-1:0] rsp_server,
    output logic [PRIO_W-1:0]   rsp_prio,
    input  logic                rej_valid,
    input  logic [NUM_W-1:0]    rej_num,
    input  logic                eoi_valid,
    input  logic [NUM_W-1:0]    eoi_num,
    input  logic                resend_req,
    output logic                dlv_valid,
    input  logic                dlv_ready,
    output logic [SRV_IN_W-1:0] dlv_server,
    output logic [NUM_W-1:0]    dlv_num,
    output logic [PRIO_W-1:0]   dlv_prio
);
    localparam int SRV_W = (NUM_SRV > 1) ? $clog2(NUM_SRV) : 1;
    localparam logic [PRIO_W-1:0] MASKED = {PRIO_W{1'b1}};

    logic [PRIO_W-1:0] prio_a      [NUM_SRC];
    logic [PRIO_W-1:0] saved_a     [NUM_SRC];
    logic [SRV_W-1:0]  srv_a       [NUM_SRC];
    logic [PRIO_W-1:0] pend_prio_a [NUM_SRC];
    logic [SRV_W-1:0]  pend_srv_a  [NUM_SRC];
    logic [NUM_SRC-1:0] pend_v, take_v, grant_v, scan_v;
    logic [NUM_SRC-1:0] cfg_dec, rej_dec, eoi_dec, cfg_hit_v;
    logic               cfg_in_rng, rej_in_rng, eoi_in_rng;
    logic [IDX_W-1:0]   cfg_loc, rej_loc, eoi_loc, pick_idx;
    logic               cfg_bad, cfg_write, pick_any;
    logic [PRIO_W-1:0]  w_prio, w_saved;
    logic [SRV_W-1:0]   w_srv;

    irq_num_dec #(.NUM_W(NUM_W), .N(NUM_SRC), .IDX_W(IDX_W), .BASE(SRC_BASE)) u_cfg_dec (
        .valid(cfg_valid), .num(cfg_num), .in_rng(cfg_in_rng), .loc(cfg_loc), .hit(cfg_dec));
    irq_num_dec #(.NUM_W(NUM_W), .N(NUM_SRC), .IDX_W(IDX_W), .BASE(SRC_BASE)) u_rej_dec (
        .valid(rej_valid), .num(rej_num), .in_rng(rej_in_rng), .loc(rej_loc), .hit(rej_dec));
    irq_num_dec #(.NUM_W(NUM_W), .N(NUM_SRC), .IDX_W(IDX_W), .BASE(SRC_BASE)) u_eoi_dec (
        .valid(eoi_valid), .num(eoi_num), .in_rng(eoi_in_rng), .loc(eoi_loc), .hit(eoi_dec));

    irq_resend_scan #(.N(NUM_SRC), .IDX_W(IDX_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .resend_req(resend_req), .scan_hit(scan_v));

    // Command legality and the field values each command writes.
    always_comb begin
        cfg_bad = !cfg_in_rng
               || ((cfg_cmd_e'(cfg_cmd) == CMD_SET)
                   && ((cfg_server >= SRV_IN_W'(NUM_SRV)) || (cfg_prio > {1'b0, MASKED})));
        cfg_write = cfg_valid && !cfg_bad && (cfg_cmd_e'(cfg_cmd) != CMD_GET);
        w_prio  = prio_a[cfg_loc];
        w_saved = saved_a[cfg_loc];
        w_srv   = srv_a[cfg_loc];
        case (cfg_cmd_e'(cfg_cmd))
            CMD_SET: begin
                w_prio  = cfg_prio[PRIO_W-1:0];
                w_saved = cfg_prio[PRIO_W-1:0];
                w_srv   = cfg_server[SRV_W-1:0];
            end
            CMD_OFF: begin
                w_prio  = MASKED;
                w_saved = prio_a[cfg_loc];
            end
            CMD_ON: begin
                w_prio  = saved_a[cfg_loc];
                w_saved = saved_a[cfg_loc];
            end
            default: ;
        endcase
        cfg_hit_v = cfg_write ? cfg_dec : '0;
    end

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            irq_src_slot #(.IS_LEVEL(LEVEL_MAP[g]), .SRV_W(SRV_W), .PRIO_W(PRIO_W)) u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .ev_hit     (ev_valid && (ev_idx == IDX_W'(g))),
                .ev_val     (ev_level),
                .rej_hit    (rej_dec[g]),
                .eoi_hit    (eoi_dec[g]),
                .cfg_hit    (cfg_hit_v[g]),
                .cfg_prio   (w_prio),
                .cfg_saved  (w_saved),
                .cfg_srv    (w_srv),
                .scan_hit   (scan_v[g]),
                .take       (take_v[g]),
                .prio_q     (prio_a[g]),
                .saved_q    (saved_a[g]),
                .srv_q      (srv_a[g]),
                .pend_q     (pend_v[g]),
                .pend_prio_q(pend_prio_a[g]),
                .pend_srv_q (pend_srv_a[g])
            );
        end
    endgenerate

    irq_dlv_pick #(.N(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .req(pend_v), .any(pick_any), .idx(pick_idx), .grant(grant_v));

    // Delivery output drawn from the granted slot.
    always_comb begin
        dlv_valid  = pick_any;
        dlv_num    = NUM_W'(SRC_BASE) + NUM_W'(pick_idx);
        dlv_prio   = pend_prio_a[pick_idx];
        dlv_server = SRV_IN_W'(pend_srv_a[pick_idx]);
        take_v     = (dlv_valid && dlv_ready) ? grant_v : '0;
    end

    // Configuration response, one cycle after the command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_err    <= 1'b0;
            rsp_server <= '0;
            rsp_prio   <= '0;
        end else begin
            rsp_valid <= cfg_valid;
            rsp_err   <= cfg_valid && cfg_bad;
            if (cfg_valid && !cfg_bad && (cfg_cmd_e'(cfg_cmd) == CMD_GET)) begin
                rsp_server <= SRV_IN_W'(srv_a[cfg_loc]);
                rsp_prio   <= prio_a[cfg_loc];
            end else begin
                rsp_server <= '0;
                rsp_prio   <= '0;
            end
        end
    end
endmodule

// File: rtl/irq_src_ctl_chk.sv
// Port-level properties of the interrupt source state controller, bound to the top.
// Assumes: the same parameter values as the bound instance.
module irq_src_ctl_chk #(
    parameter int NUM_SRC  = 8,
    parameter int SRC_BASE = 16,
    parameter int NUM_SRV  = 4,
    parameter int NUM_W    = 12,
    parameter int SRV_IN_W = 8,
    parameter int PRIO_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_valid,
    input logic [1:0]          cfg_cmd,
    input logic [NUM_W-1:0]    cfg_num,
    input logic [SRV_IN_W-1:0] cfg_server,
    input logic                rsp_valid,
    input logic                rsp_err,
    input logic                dlv_valid,
    input logic                dlv_ready,
    input logic [SRV_IN_W-1:0] dlv_server,
    input logic [NUM_W-1:0]    dlv_num,
    input logic [PRIO_W-1:0]   dlv_prio
);
    localparam logic [PRIO_W-1:0] MASKED = {PRIO_W{1'b1}};

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!dlv_valid && !rsp_valid));

    a_r12_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> rsp_valid);

    a_r12_rsp_only_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |=> !rsp_valid);

    a_r3_range_err: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && ((cfg_num < NUM_W'(SRC_BASE)) || (cfg_num >= NUM_W'(SRC_BASE + NUM_SRC))))
        |=> rsp_err);

    a_r3_bad_server_err: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && (cfg_cmd == 2'd1) && (cfg_server >= SRV_IN_W'(NUM_SRV))) |=> rsp_err);

    a_r4_no_masked_dlv: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> (dlv_prio != MASKED));

    a_r13_num_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> ((dlv_num >= NUM_W'(SRC_BASE)) && (dlv_num < NUM_W'(SRC_BASE + NUM_SRC))));

    a_r13_server_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> (dlv_server < SRV_IN_W'(NUM_SRV)));

    a_r13_hold_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && !dlv_ready) |=> dlv_valid);
endmodule

bind irq_src_ctl irq_src_ctl_chk #(
    .NUM_SRC(NUM_SRC), .SRC_BASE(SRC_BASE), .NUM_SRV(NUM_SRV),
    .NUM_W(NUM_W), .SRV_IN_W(SRV_IN_W), .PRIO_W(PRIO_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_cmd(cfg_cmd),
    .cfg_num(cfg_num), .cfg_server(cfg_server), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
    .dlv_server(dlv_server), .dlv_num(dlv_num), .dlv_prio(dlv_prio)
);

// File: tb/sim_irq_src_ctl.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module sim_irq_src_ctl;
    localparam int NSRC = 8;
    localparam logic [1:0] OP_GET = 2'd0, OP_SET = 2'd1, OP_OFF = 2'd2, OP_ON = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0, ev_level = 1'b0;
    logic [2:0]  ev_idx = '0;
    logic        cfg_valid = 1'b0;
    logic [1:0]  cfg_cmd = '0;
    logic [11:0] cfg_num = '0;
    logic [7:0]  cfg_server = '0;
    logic [8:0]  cfg_prio = '0;
    logic        rsp_valid, rsp_err;
    logic [7:0]  rsp_server, rsp_prio;
    logic        rej_valid = 1'b0, eoi_valid = 1'b0, resend_req = 1'b0;
    logic [11:0] rej_num = '0, eoi_num = '0;
    logic        dlv_valid, dlv_ready = 1'b0;
    logic [7:0]  dlv_server, dlv_prio;
    logic [11:0] dlv_num;
    int          n_checks = 0, n_fail = 0;

    irq_src_ctl u0 (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_idx(ev_idx), .ev_level(ev_level),
        .cfg_valid(cfg_valid), .cfg_cmd(cfg_cmd), .cfg_num(cfg_num), .cfg_server(cfg_server),
        .cfg_prio(cfg_prio), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_server(rsp_server),
        .rsp_prio(rsp_prio), .rej_valid(rej_valid), .rej_num(rej_num), .eoi_valid(eoi_valid),
        .eoi_num(eoi_num), .resend_req(resend_req), .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
        .dlv_server(dlv_server), .dlv_num(dlv_num), .dlv_prio(dlv_prio));

    always #2 clk = ~clk;

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic src_ev(input int idx, input bit val);
        ev_valid = 1'b1; ev_idx = 3'(idx); ev_level = val;
        tick();
        ev_valid = 1'b0;
    endtask

    task automatic cfg(input logic [1:0] op, input int num, input int srv, input int prio);
        cfg_valid = 1'b1; cfg_cmd = op; cfg_num = 12'(num);
        cfg_server = 8'(srv); cfg_prio = 9'(prio);
        tick();
        cfg_valid = 1'b0;
    endtask

    task automatic rej(input int num);
        rej_valid = 1'b1; rej_num = 12'(num);
        tick();
        rej_valid = 1'b0;
    endtask

    task automatic eoi(input int num);
        eoi_valid = 1'b1; eoi_num = 12'(num);
        tick();
        eoi_valid = 1'b0;
    endtask

    task automatic resend();
        resend_req = 1'b1;
        tick();
        resend_req = 1'b0;
        repeat (NSRC + 1) tick();
    endtask

    task automatic expect_rsp(input string tag, input bit err, input int srv, input int prio);
        chk(rsp_valid == 1'b1, {tag, " rsp_valid"}, int'(rsp_valid), 1);
        chk(rsp_err == err, {tag, " rsp_err"}, int'(rsp_err), int'(err));
        if (!err) begin
            chk(rsp_server == 8'(srv), {tag, " rsp_server"}, int'(rsp_server), srv);
            chk(rsp_prio == 8'(prio), {tag, " rsp_prio"}, int'(rsp_prio), prio);
        end
    endtask

    task automatic expect_dlv(input string tag, input int num, input int srv, input int prio);
        chk(dlv_valid == 1'b1, {tag, " dlv_valid"}, int'(dlv_valid), 1);
        chk(dlv_num == 12'(num), {tag, " dlv_num"}, int'(dlv_num), num);
        chk(dlv_server == 8'(srv), {tag, " dlv_server"}, int'(dlv_server), srv);
        chk(dlv_prio == 8'(prio), {tag, " dlv_prio"}, int'(dlv_prio), prio);
        dlv_ready = 1'b1;
        tick();
        dlv_ready = 1'b0;
    endtask

    task automatic expect_none(input string tag);
        chk(dlv_valid == 1'b0, {tag, " no delivery"}, int'(dlv_valid), 0);
    endtask

    task automatic t_reset();
        expect_none("R1 after reset");
        chk(rsp_valid == 1'b0, "R1 no response", int'(rsp_valid), 0);
        cfg(OP_GET, 16, 0, 0);
        expect_rsp("R1 reset prio", 1'b0, 0, 255);
    endtask

    task automatic t_range();
        cfg(OP_GET, 15, 0, 0);   expect_rsp("R3 below base", 1'b1, 0, 0);
        cfg(OP_GET, 24, 0, 0);   expect_rsp("R3 above top", 1'b1, 0, 0);
        cfg(OP_SET, 17, 4, 3);   expect_rsp("R3 bad server", 1'b1, 0, 0);
        cfg(OP_SET, 17, 1, 256); expect_rsp("R3 bad prio", 1'b1, 0, 0);
        cfg(OP_GET, 17, 0, 0);   expect_rsp("R3 no change R2", 1'b0, 0, 255);
    endtask

    task automatic t_msg();
        src_ev(0, 1'b1);         expect_none("R4 masked event");
        cfg(OP_SET, 16, 2, 5);   expect_dlv("R11 mpend release", 16, 2, 5);
        cfg(OP_SET, 16, 2, 5);   expect_none("R11 mpend cleared");
        src_ev(0, 1'b1);         expect_dlv("R4 live event", 16, 2, 5);
        src_ev(0, 1'b0);         expect_none("R4 low message event");
    endtask

    task automatic t_level();
        cfg(OP_SET, 20, 1, 3);   expect_none("R6 not asserted");
        src_ev(4, 1'b1);         expect_dlv("R5 assert delivers", 20, 1, 3);
        src_ev(4, 1'b1);         expect_none("R6 sent blocks");
        eoi(20);                 expect_none("R8 eoi alone");
        resend();                expect_dlv("R9 level resend", 20, 1, 3);
        resend();                expect_none("R9 sent again");
        rej(20);                 expect_none("R7 reject level");
        src_ev(4, 1'b0);         expect_none("R5 deassert");
        resend();                expect_none("R9 not asserted");
        src_ev(4, 1'b1);         expect_dlv("R7 sent cleared by reject", 20, 1, 3);
    endtask

    task automatic t_msg_reject();
        rej(16);                 expect_none("R7 reject msg");
        eoi(16);                 expect_none("R8 eoi msg");
        resend();                expect_dlv("R10 rejected redelivered", 16, 2, 5);
        resend();                expect_none("R10 flag cleared");
    endtask

    task automatic t_off_on();
        rej(16);
        cfg(OP_OFF, 16, 0, 0);   expect_rsp("R12 off", 1'b0, 0, 0);
        cfg(OP_GET, 16, 0, 0);   expect_rsp("R12 off prio", 1'b0, 2, 255);
        resend();                expect_none("R10 masked resend");
        cfg(OP_ON, 16, 0, 0);    expect_none("R12 on no pending");
        cfg(OP_GET, 16, 0, 0);   expect_rsp("R12 on prio", 1'b0, 2, 5);
        resend();                expect_none("R10 rejected consumed");
        cfg(OP_OFF, 16, 0, 0);
        src_ev(0, 1'b1);         expect_none("R4 event while off");
        cfg(OP_ON, 16, 0, 0);    expect_dlv("R12 on releases", 16, 2, 5);
    endtask

    task automatic t_level_cfg();
        src_ev(5, 1'b1);         expect_none("R6 masked level");
        cfg(OP_SET, 21, 3, 7);   expect_dlv("R11 level on write", 21, 3, 7);
    endtask

    task automatic t_order();
        cfg(OP_SET, 17, 1, 4);
        cfg(OP_SET, 18, 0, 9);
        rej(18); rej(16); rej(17);
        resend();
        tick();
        expect_dlv("R13 order first", 16, 2, 5);
        expect_dlv("R13 order second", 17, 1, 4);
        expect_dlv("R13 order third", 18, 0, 9);
        expect_none("R13 drained");
        src_ev(1, 1'b1);
        src_ev(1, 1'b1);
        expect_dlv("R13 merged", 17, 1, 4);
        expect_none("R13 single after merge");
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_range();
        t_msg();
        t_level();
        t_msg_reject();
        t_off_on();
        t_level_cfg();
        t_order();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(4 * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule